// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block sits beside a processor pipeline and decides, every clock, which pending exception cause the core services next. The causes are a reset request, an undefined instruction, a software trap, an instruction fetch abort, a data abort, a fast interrupt and a normal interrupt. The two interrupt lines are gated by the disable bits of the current status word. The three synchronous faults and reset are never gated. For the winning cause the block produces the whole entry package in one registered step: the new status word, the value for the target mode's saved-status register, the value for the target mode's link register and the vector fetch address. An entry strobe marks that step and a cause code names the winner, so the source of that cause can retire it. Causes that lost stay asserted by their sources and are taken on a later cycle.

The block also keeps one saved-status copy for each exception mode: supervisor, undefined, abort, normal interrupt and fast interrupt. It serves an exception-return request by reading the copy that belongs to the current mode. It returns that copy as the status word to restore. The resume PC it returns is the supplied link value minus a selectable correction. The register file, instruction decode and any external interrupt controller stay outside the block.

Top module: `exc_entry_seq`

## Requirements
- R1: Causes are ranked, highest first: reset, data abort, fast interrupt, normal interrupt, fetch abort, undefined instruction, software trap. At most one entry occurs per cycle. `ent_code` names the winner: reset 0, undefined 1, trap 2, fetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7.
- R2: `ent_vec` equals the base plus `ent_code` times 4. The base is 0 when `hivec` is low and 0xFFFF0000 when it is high. The fast interrupt uses the last slot, offset 0x1C.
- R3: `ent_mode`, and bits [4:0] of `ent_psr`, carry the target mode code: 0b10011 for reset and trap, 0b11011 for undefined, 0b10111 for either abort, 0b10010 for the normal interrupt and 0b10001 for the fast interrupt.
- R4: On every entry, `ent_psr` bit 5 is 0 and bit 7 is 1. Bits 31:8 are copied from `cur_psr`.
- R5: `ent_psr` bit 6 is set on reset and fast interrupt entry. For every other cause it equals `cur_psr` bit 6.
- R6: A normal interrupt is taken only when `cur_psr` bit 7 is 0. A fast interrupt is taken only when `cur_psr` bit 6 is 0. A masked interrupt with no other cause gives no entry. The other causes are taken whatever the mask bits hold.
- R7: `ent_spsr` equals the `cur_psr` sampled with the request, for every cause including reset. That value is also stored in the block's saved-status copy for the target mode.
- R8: `ent_lr` equals the sampled `cur_pc` plus 4. On reset entry it is 0.
- R9: A return request while `cur_psr[4:0]` names an exception mode gives `ret_vld`. `ret_psr` then holds that mode's saved-status copy. `ret_pc` equals `ret_link` minus a correction chosen by `ret_adj`: 0 gives 0, 1 gives 4, and 2 or 3 give 8.
- R10: A return request is dropped, with `ret_vld` low, when `cur_psr[4:0]` is user (0b10000) or system (0b11111), or when any entry occurs in the same cycle.
- R11: All results are registered and appear one cycle after the inputs are sampled. A strobe lasts one cycle per sampled request. After reset both strobes are low and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block's registers |
| rq_reset | input | 1 | Reset exception pending |
| rq_undef | input | 1 | Undefined instruction pending |
| rq_trap | input | 1 | Software trap pending |
| rq_pabt | input | 1 | Instruction fetch abort pending |
| rq_dabt | input | 1 | Data abort pending |
| rq_fiq | input | 1 | Fast interrupt line |
| rq_irq | input | 1 | Normal interrupt line |
| cur_psr | input | SW | Current status word |
| cur_pc | input | AW | PC of the faulting or interrupted instruction |
| hivec | input | 1 | Selects the high vector base |
| ret_req | input | 1 | Exception-return request |
| ret_adj | input | 2 | Return correction select |
| ret_link | input | AW | Link value of the current mode |
| ent_vld | output | 1 | Entry strobe |
| ent_code | output | 3 | Cause taken, equal to the vector slot |
| ent_mode | output | 5 | Target mode code |
| ent_psr | output | SW | New status word |
| ent_spsr | output | SW | Value for the target saved-status register |
| ent_lr | output | AW | Value for the target link register |
| ent_vec | output | AW | Vector fetch address |
| ret_vld | output | 1 | Return strobe |
| ret_psr | output | SW | Status word to restore |
| ret_pc | output | AW | Resume PC |

## Verification
Every result, from entry and from return alike, is due exactly one clock edge after the inputs that cause it are sampled. A saved-status copy written by an entry can be read by a return request in the very next cycle. The bench drives each stimulus on a falling edge and reads the outputs shortly after the next rising edge. The following falling edge either clears the request or applies the next one, so each check sees only the result of the cycle it aims at. A strobe that must not appear is checked in the same slot as one that must.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int AW = 32,
  parameter int SW = 32,
  parameter logic [AW-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rq_reset,
  input  logic          rq_undef,
  input  logic          rq_trap,
  input  logic          rq_pabt,
  input  logic          rq_dabt,
  input  logic          rq_fiq,
  input  logic          rq_irq,
  input  logic [SW-1:0] cur_psr,
  input  logic [AW-1:0] cur_pc,
  input  logic          hivec,
  input  logic          ret_req,
  input  logic [1:0]    ret_adj,
  input  logic [AW-1:0] ret_link,
  output logic          ent_vld,
  output logic [2:0]    ent_code,
  output logic [4:0]    ent_mode,
  output logic [SW-1:0] ent_psr,
  output logic [SW-1:0] ent_spsr,
  output logic [AW-1:0] ent_lr,
  output logic [AW-1:0] ent_vec,
  output logic          ret_vld,
  output logic [SW-1:0] ret_psr,
  output logic [AW-1:0] ret_pc
);

  localparam int NB = 5;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_FIQ = 5'b10001;

  logic          take;
  logic [2:0]    code;
  logic [4:0]    mode;
  logic [2:0]    tgt_bank;
  logic [2:0]    cur_bank;
  logic          cur_ok;
  logic [SW-1:0] new_psr;
  logic [SW-1:0] bank_rd;
  logic [AW-1:0] corr;
  logic          do_ret;
  logic [SW-1:0] bank_q [NB];

  wire fiq_ok = rq_fiq & ~cur_psr[6];
  wire irq_ok = rq_irq & ~cur_psr[7];

  always_comb begin
    take = 1'b1;
    code = 3'd0;
    if (rq_reset)     code = 3'd0;
    else if (rq_dabt) code = 3'd4;
    else if (fiq_ok)  code = 3'd7;
    else if (irq_ok)  code = 3'd6;
    else if (rq_pabt) code = 3'd3;
    else if (rq_undef) code = 3'd1;
    else if (rq_trap) code = 3'd2;
    else take = 1'b0;
  end

  always_comb begin
    case (code)
      3'd1:         begin mode = M_UND; tgt_bank = 3'd1; end
      3'd3, 3'd4:   begin mode = M_ABT; tgt_bank = 3'd2; end
      3'd6:         begin mode = M_IRQ; tgt_bank = 3'd3; end
      3'd7:         begin mode = M_FIQ; tgt_bank = 3'd4; end
      default:      begin mode = M_SVC; tgt_bank = 3'd0; end
    endcase
  end

  always_comb begin
    cur_ok = 1'b1;
    case (cur_psr[4:0])
      M_SVC:   cur_bank = 3'd0;
      M_UND:   cur_bank = 3'd1;
      M_ABT:   cur_bank = 3'd2;
      M_IRQ:   cur_bank = 3'd3;
      M_FIQ:   cur_bank = 3'd4;
      default: begin cur_bank = 3'd0; cur_ok = 1'b0; end
    endcase
  end

  always_comb begin
    new_psr      = cur_psr;
    new_psr[4:0] = mode;
    new_psr[5]   = 1'b0;
    new_psr[7]   = 1'b1;
    if (code == 3'd0 || code == 3'd7) new_psr[6] = 1'b1;
  end

  always_comb begin
    bank_rd = '0;
    for (int i = 0; i < NB; i++)
      if (cur_bank == 3'(i)) bank_rd = bank_q[i];
  end

  assign corr   = (ret_adj == 2'd0) ? '0 : (ret_adj == 2'd1) ? AW'(4) : AW'(8);
  assign do_ret = ret_req & ~take & cur_ok;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) bank_q[g] <= '0;
      else if (take && tgt_bank == 3'(g)) bank_q[g] <= cur_psr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld  <= 1'b0;
      ent_code <= '0;
      ent_mode <= '0;
      ent_psr  <= '0;
      ent_spsr <= '0;
      ent_lr   <= '0;
      ent_vec  <= '0;
      ret_vld  <= 1'b0;
      ret_psr  <= '0;
      ret_pc   <= '0;
    end else begin
      ent_vld <= take;
      ret_vld <= do_ret;
      if (take) begin
        ent_code <= code;
        ent_mode <= mode;
        ent_psr  <= new_psr;
        ent_spsr <= cur_psr;
        ent_lr   <= (code == 3'd0) ? '0 : cur_pc + AW'(4);
        ent_vec  <= (hivec ? HI_BASE : '0) + (AW'(code) << 2);
      end
      if (do_ret) begin
        ret_psr <= bank_rd;
        ret_pc  <= ret_link - corr;
      end
    end
  end

endmodule

module exc_entry_seq_chk #(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rq_reset,
  input logic          rq_dabt,
  input logic          rq_fiq,
  input logic [SW-1:0] cur_psr,
  input logic [AW-1:0] cur_pc,
  input logic          ent_vld,
  input logic [2:0]    ent_code,
  input logic [SW-1:0] ent_psr,
  input logic [AW-1:0] ent_lr,
  input logic          ret_vld
);

  a_r4_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ent_vld |-> (ent_psr[7] && !ent_psr[5]));

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld && ent_code == 3'd6) |-> !$past(cur_psr[7]));

  a_r6_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld && ent_code == 3'd7) |-> !$past(cur_psr[6]));

  a_r1_fiq_rank: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_fiq && !cur_psr[6] && !rq_reset && !rq_dabt) |=> (ent_vld && ent_code == 3'd7));

  a_r8_link: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld && ent_code != 3'd0) |-> (ent_lr == $past(cur_pc) + AW'(4)));

  a_r5_fiq_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld && ent_code != 3'd0 && ent_code != 3'd7) |-> (ent_psr[6] == $past(cur_psr[6])));

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(ent_vld && ret_vld));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rq_reset(rq_reset), .rq_dabt(rq_dabt),
  .rq_fiq(rq_fiq), .cur_psr(cur_psr), .cur_pc(cur_pc), .ent_vld(ent_vld),
  .ent_code(ent_code), .ent_psr(ent_psr), .ent_lr(ent_lr), .ret_vld(ret_vld)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rq_reset = 0, rq_undef = 0, rq_trap = 0, rq_pabt = 0;
  logic        rq_dabt = 0, rq_fiq = 0, rq_irq = 0;
  logic [31:0] cur_psr = '0, cur_pc = '0, ret_link = '0;
  logic        hivec = 0, ret_req = 0;
  logic [1:0]  ret_adj = '0;
  logic        ent_vld, ret_vld;
  logic [2:0]  ent_code;
  logic [4:0]  ent_mode;
  logic [31:0] ent_psr, ent_spsr, ent_lr, ent_vec, ret_psr, ret_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // cause mask bits: 0 reset, 1 undef, 2 trap, 3 fetch abort, 4 data abort, 5 fast irq, 6 irq
  localparam logic [6:0] C_RST = 7'h01, C_UND = 7'h02, C_TRP = 7'h04, C_PAB = 7'h08;
  localparam logic [6:0] C_DAB = 7'h10, C_FIQ = 7'h20, C_IRQ = 7'h40;

  always #2 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .rq_reset(rq_reset), .rq_undef(rq_undef),
    .rq_trap(rq_trap), .rq_pabt(rq_pabt), .rq_dabt(rq_dabt), .rq_fiq(rq_fiq),
    .rq_irq(rq_irq), .cur_psr(cur_psr), .cur_pc(cur_pc), .hivec(hivec),
    .ret_req(ret_req), .ret_adj(ret_adj), .ret_link(ret_link),
    .ent_vld(ent_vld), .ent_code(ent_code), .ent_mode(ent_mode),
    .ent_psr(ent_psr), .ent_spsr(ent_spsr), .ent_lr(ent_lr), .ent_vec(ent_vec),
    .ret_vld(ret_vld), .ret_psr(ret_psr), .ret_pc(ret_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] c, input logic [31:0] psr, input logic [31:0] pc,
                      input logic hv, input logic rr, input logic [1:0] adj, input logic [31:0] lnk);
    @(negedge clk);
    {rq_irq, rq_fiq, rq_dabt, rq_pabt, rq_trap, rq_undef, rq_reset} = c;
    cur_psr = psr; cur_pc = pc; hivec = hv; ret_req = rr; ret_adj = adj; ret_link = lnk;
    @(posedge clk);
    #1;
    @(negedge clk);
    {rq_irq, rq_fiq, rq_dabt, rq_pabt, rq_trap, rq_undef, rq_reset} = '0;
    ret_req = 0;
  endtask

  function automatic int exp_code(input logic [6:0] c, input logic [31:0] psr);
    if (c[0]) return 0;
    if (c[4]) return 4;
    if (c[5] && !psr[6]) return 7;
    if (c[6] && !psr[7]) return 6;
    if (c[3]) return 3;
    if (c[1]) return 1;
    if (c[2]) return 2;
    return -1;
  endfunction

  function automatic logic [4:0] exp_mode(input int code);
    case (code)
      1: return 5'b11011;
      3, 4: return 5'b10111;
      6: return 5'b10010;
      7: return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  // drive one entry and check the whole package
  task automatic entry(input string tag, input logic [6:0] c, input logic [31:0] psr,
                       input logic [31:0] pc, input logic hv);
    int code;
    logic [31:0] epsr;
    code = exp_code(c, psr);
    @(negedge clk);
    {rq_irq, rq_fiq, rq_dabt, rq_pabt, rq_trap, rq_undef, rq_reset} = c;
    cur_psr = psr; cur_pc = pc; hivec = hv; ret_req = 0;
    @(posedge clk);
    #1;
    if (code < 0) begin
      chk({tag, " R6 no entry"}, 32'(ent_vld), 32'd0);
    end else begin
      epsr = {psr[31:8], 1'b1, (code == 0 || code == 7) ? 1'b1 : psr[6], 1'b0, exp_mode(code)};
      chk({tag, " R1 strobe"}, 32'(ent_vld), 32'd1);
      chk({tag, " R1 code"}, 32'(ent_code), 32'(code));
      chk({tag, " R3 mode"}, 32'(ent_mode), 32'(exp_mode(code)));
      chk({tag, " R4 R5 status"}, ent_psr, epsr);
      chk({tag, " R7 saved"}, ent_spsr, psr);
      chk({tag, " R8 link"}, ent_lr, (code == 0) ? 32'd0 : pc + 32'd4);
      chk({tag, " R2 vector"}, ent_vec, (hv ? 32'hFFFF_0000 : 32'd0) + 32'(code * 4));
    end
    @(negedge clk);
    {rq_irq, rq_fiq, rq_dabt, rq_pabt, rq_trap, rq_undef, rq_reset} = '0;
    @(posedge clk);
    #1;
    chk({tag, " R11 strobe single"}, 32'(ent_vld), 32'd0);
  endtask

  task automatic t_reset_state;
    chk("R11 reset ent_vld", 32'(ent_vld), 0);
    chk("R11 reset ret_vld", 32'(ret_vld), 0);
    chk("R11 reset ent_vec", ent_vec, 0);
    chk("R11 reset ret_pc", ret_pc, 0);
  endtask

  task automatic t_single;
    logic [6:0] list [7] = '{C_RST, C_UND, C_TRP, C_PAB, C_DAB, C_FIQ, C_IRQ};
    for (int i = 0; i < 7; i++) begin
      entry("single lo", list[i], 32'h3C00_0010, 32'h0000_8000 + 32'(i * 16), 1'b0);
      entry("single hi", list[i], 32'hC300_011F, 32'h1234_5670, 1'b1);
    end
  endtask

  task automatic t_priority;
    entry("R1 all", 7'h7F, 32'h0000_0010, 32'h100, 0);
    entry("R1 dabt>fiq", C_DAB | C_FIQ | C_IRQ | C_PAB, 32'h0000_0010, 32'h200, 0);
    entry("R1 fiq>irq", C_FIQ | C_IRQ | C_PAB, 32'h0000_0010, 32'h300, 0);
    entry("R1 irq>pabt", C_IRQ | C_PAB | C_UND, 32'h0000_0010, 32'h400, 0);
    entry("R1 pabt>undef", C_PAB | C_UND | C_TRP, 32'h0000_0010, 32'h500, 1);
    entry("R1 undef>trap", C_UND | C_TRP, 32'h0000_0010, 32'h600, 0);
  endtask

  task automatic t_masking;
    entry("R6 irq masked", C_IRQ, 32'h0000_0090, 32'h700, 0);
    entry("R6 fiq masked", C_FIQ, 32'h0000_0050, 32'h710, 0);
    entry("R6 fiq masked irq open", C_FIQ | C_IRQ, 32'h0000_0050, 32'h720, 0);
    entry("R6 trap unmaskable", C_TRP, 32'h0000_00D0, 32'h730, 0);
    entry("R6 dabt unmaskable", C_DAB | C_IRQ, 32'h0000_00D0, 32'h740, 1);
    entry("R5 undef keeps bit6", C_UND, 32'h0000_0050, 32'h750, 0);
  endtask

  task automatic t_return;
    step(C_IRQ, 32'hA5A5_0010, 32'h900, 0, 0, 0, 0);
    step(0, 32'hA5A5_0092, 0, 0, 1, 2'd1, 32'h0000_2000);
    chk("R9 ret strobe irq", 32'(ret_vld), 1);
    chk("R9 ret status irq", ret_psr, 32'hA5A5_0010);
    chk("R9 ret pc minus 4", ret_pc, 32'h0000_1FFC);
    step(C_FIQ, 32'h5A5A_0113, 32'h910, 0, 0, 0, 0);
    step(0, 32'h5A5A_01D1, 0, 0, 1, 2'd0, 32'h0000_3000);
    chk("R9 ret status fiq", ret_psr, 32'h5A5A_0113);
    chk("R9 ret pc minus 0", ret_pc, 32'h0000_3000);
    step(C_DAB, 32'h0F0F_0010, 32'h920, 0, 0, 0, 0);
    step(0, 32'h0F0F_0097, 0, 0, 1, 2'd2, 32'h0000_4000);
    chk("R9 ret status abort", ret_psr, 32'h0F0F_0010);
    chk("R9 ret pc minus 8", ret_pc, 32'h0000_3FF8);
    step(0, 32'h0F0F_0097, 0, 0, 1, 2'd3, 32'h0000_4000);
    chk("R9 ret adj 3", ret_pc, 32'h0000_3FF8);
    step(C_RST, 32'h7777_0010, 32'h930, 0, 0, 0, 0);
    step(0, 32'h0000_00D3, 0, 0, 1, 2'd1, 32'h0000_0010);
    chk("R7 reset saved copy", ret_psr, 32'h7777_0010);
  endtask

  task automatic t_ret_ignore;
    step(0, 32'h0000_0010, 0, 0, 1, 2'd1, 32'h0000_5000);
    chk("R10 ret user dropped", 32'(ret_vld), 0);
    step(0, 32'h0000_001F, 0, 0, 1, 2'd1, 32'h0000_5000);
    chk("R10 ret system dropped", 32'(ret_vld), 0);
    step(C_TRP, 32'h0000_0092, 32'hA00, 0, 1, 2'd1, 32'h0000_5000);
    chk("R10 ret with entry dropped", 32'(ret_vld), 0);
    chk("R10 entry wins", 32'(ent_vld), 1);
    chk("R10 entry code", 32'(ent_code), 2);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_single();
    t_priority();
    t_masking();
    t_return();
    t_ret_ignore();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule